// File: doc/BRIEF.md
# Decode-Stage Load and Branch Hazard Stall Unit

This block decides, every cycle, whether the instruction now sitting in the decode stage may move on. It looks at the two source register numbers of that instruction, at the instruction one stage ahead in execute (is it a load, and which register does it produce), and at the instruction two stages ahead in memory (is it a load, and which register it produces). When the decode instruction would read a value that cannot yet be forwarded, the unit freezes the program counter and the fetch/decode register and tells the decode/execute register to capture a bubble with all of its control bits cleared.

Two kinds of dependency are caught. A load followed at once by any reader of its result costs one bubble; after it the loaded value is forwarded from the memory/writeback register. A branch that is compared in decode needs its operands one stage earlier than an ALU does, so it also waits when the instruction just ahead is an ALU op writing one of its operands, or when a load two instructions earlier writes one. A load directly ahead of such a branch costs two bubbles. That second bubble comes about on its own: the request is purely combinational, and once the load reaches the memory stage the second rule fires. The decoder is expected to supply a destination of register zero for an instruction that writes no register, and the bubble it writes into decode/execute carries all fields cleared.

Top module: `hazard_stall_unit`

## Requirements
- R1: When `ex_is_load` is 1 and `ex_load_dst` is nonzero and equal to `dec_src_a` or to `dec_src_b`, a stall is raised, whether or not `dec_is_branch` is set.
- R2: A stall drives `pc_write` = 0, `ifid_write` = 0 and `ctrl_zero` = 1; with no stall the three are 1, 1 and 0.
- R3: When `dec_is_branch` is 1, `ex_is_load` is 0 and `ex_alu_dst` is nonzero and equal to either source, a stall is raised.
- R4: When `dec_is_branch` is 1, `mem_is_load` is 1 and `mem_load_dst` is nonzero and equal to either source, a stall is raised.
- R5: A branch reading the register written by the load directly ahead of it is held for exactly two cycles in the pipeline.
- R6: A destination of register zero never raises a stall by any rule.
- R7: Matches that the rules above do not name raise no stall: a non-branch reading `ex_alu_dst` or `mem_load_dst`, and any instruction when neither load flag is set and no branch is decoded.
- R8: A load followed by a non-branch reader of its result is held for exactly one cycle, and an ALU op directly ahead of a branch costs that branch exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| dec_is_branch | input | 1 | Decode instruction is a branch compared in decode |
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| ex_load_dst | input | REG_W | Register a load in execute will write |
| ex_alu_dst | input | REG_W | Register an ALU op in execute will write (0 if none) |
| mem_is_load | input | 1 | Memory-stage instruction reads data memory |
| mem_load_dst | input | REG_W | Register the memory-stage instruction will write |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | Fetch/decode register may load |
| ctrl_zero | output | 1 | Clear every control bit entering decode/execute |

## Verification
The bench goes after the register-zero case, where a design missing the guard would stall on every load into register zero or on every branch behind a non-writing instruction. It checks that a non-branch ignores an ALU result ahead of it, which a design applying the branch rule too widely would turn into needless bubbles. It runs a program through a modelled pipeline so that the load-then-branch pair must cost exactly two cycles and a load-then-use exactly one; a design that dropped the memory-stage rule would release the branch a cycle early, and one that latched the stall would hold too long.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  // True when a producer register blocks a consumer register.
  // Register zero is hard-wired and never produces a hazard.
  function automatic logic reg_blocks(input logic [7:0] dst, input logic [7:0] src);
    return (dst != 8'd0) && (dst == src);
  endfunction
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC*REG_W-1:0] srcs,
  input  logic                  ex_is_load,
  input  logic [REG_W-1:0]      ex_load_dst,
  output logic                  hit
);
  import hazard_pkg::*;
  localparam int PADW = 8 - REG_W;

  logic [NSRC-1:0] per_src;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign per_src[g] = ex_is_load &&
      reg_blocks({{PADW{1'b0}}, ex_load_dst}, {{PADW{1'b0}}, srcs[g*REG_W +: REG_W]});
  end

  assign hit = |per_src;

  always_comb begin
    p_lu_needs_load_r1: assert (!hit || ex_is_load);
    p_lu_zero_dst_r6: assert (!(hit && ex_load_dst == '0));
  end
endmodule

// File: rtl/hz_branch_dep.sv
module hz_branch_dep #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC*REG_W-1:0] srcs,
  input  logic                  dec_is_branch,
  input  logic                  ex_is_load,
  input  logic [REG_W-1:0]      ex_alu_dst,
  input  logic                  mem_is_load,
  input  logic [REG_W-1:0]      mem_load_dst,
  output logic                  alu_hit,
  output logic                  mem_hit
);
  import hazard_pkg::*;
  localparam int PADW = 8 - REG_W;

  logic [NSRC-1:0] alu_src, mem_src;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [7:0] s;
    assign s = {{PADW{1'b0}}, srcs[g*REG_W +: REG_W]};
    assign alu_src[g] = reg_blocks({{PADW{1'b0}}, ex_alu_dst}, s);
    assign mem_src[g] = reg_blocks({{PADW{1'b0}}, mem_load_dst}, s);
  end

  assign alu_hit = dec_is_branch && !ex_is_load && (|alu_src);
  assign mem_hit = dec_is_branch && mem_is_load && (|mem_src);

  always_comb begin
    p_br_alu_needs_branch_r3: assert (!alu_hit || (dec_is_branch && ex_alu_dst != '0));
    p_br_mem_needs_load_r4: assert (!mem_hit || (mem_is_load && mem_load_dst != '0));
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_is_branch,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_load_dst,
  input  logic [REG_W-1:0] ex_alu_dst,
  input  logic             mem_is_load,
  input  logic [REG_W-1:0] mem_load_dst,
  output logic             pc_write,
  output logic             ifid_write,
  output logic             ctrl_zero
);
  localparam int NSRC = 2;

  logic [NSRC*REG_W-1:0] srcs;
  logic lu_hit, br_alu_hit, br_mem_hit, stall_req;

  assign srcs = {dec_src_b, dec_src_a};

  hz_load_use #(.REG_W(REG_W), .NSRC(NSRC)) u_lu (
    .srcs(srcs), .ex_is_load(ex_is_load), .ex_load_dst(ex_load_dst), .hit(lu_hit)
  );

  hz_branch_dep #(.REG_W(REG_W), .NSRC(NSRC)) u_br (
    .srcs(srcs), .dec_is_branch(dec_is_branch), .ex_is_load(ex_is_load),
    .ex_alu_dst(ex_alu_dst), .mem_is_load(mem_is_load), .mem_load_dst(mem_load_dst),
    .alu_hit(br_alu_hit), .mem_hit(br_mem_hit)
  );

  assign stall_req  = lu_hit | br_alu_hit | br_mem_hit;
  assign pc_write   = !stall_req;
  assign ifid_write = !stall_req;
  assign ctrl_zero  = stall_req;

  always_comb begin
    p_outputs_agree_r2: assert (pc_write == ifid_write && ctrl_zero != pc_write);
    p_zero_srcs_never_r6: assert (!(ctrl_zero && dec_src_a == '0 && dec_src_b == '0));
    p_idle_no_stall_r7: assert (ex_is_load || mem_is_load || dec_is_branch || pc_write);
  end
endmodule

// File: tb/hazard_stall_unit_tb.sv
module hazard_stall_unit_tb;
  localparam int REG_W = 5;
  localparam int ALU = 0, LD = 1, BR = 2, NOP = 3;
  localparam int NPROG = 14;

  logic clk = 0;
  always #10 clk = ~clk;

  logic [REG_W-1:0] dec_src_a = 0, dec_src_b = 0, ex_load_dst = 0, ex_alu_dst = 0, mem_load_dst = 0;
  logic dec_is_branch = 0, ex_is_load = 0, mem_is_load = 0;
  logic pc_write, ifid_write, ctrl_zero;

  hazard_stall_unit #(.REG_W(REG_W)) u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  int kind [NPROG], rs [NPROG], rt [NPROG], dst [NPROG];
  int stalls_of [NPROG];

  task automatic check_out(input bit exp_stall, input string tag);
    checks++;
    if (pc_write !== !exp_stall || ifid_write !== !exp_stall || ctrl_zero !== exp_stall) begin
      fails++;
      $display("FAIL %s: pc_write=%b ifid_write=%b ctrl_zero=%b expected stall=%0d",
               tag, pc_write, ifid_write, ctrl_zero, exp_stall);
    end
  endtask

  task automatic drive(input int a, input int b, input bit br, input bit exl, input int exld,
                       input int exad, input bit meml, input int memd);
    dec_src_a = a[REG_W-1:0]; dec_src_b = b[REG_W-1:0]; dec_is_branch = br;
    ex_is_load = exl; ex_load_dst = exld[REG_W-1:0]; ex_alu_dst = exad[REG_W-1:0];
    mem_is_load = meml; mem_load_dst = memd[REG_W-1:0];
    #2;
  endtask

  task automatic set_instr(input int i, input int k, input int s, input int t, input int d);
    kind[i] = k; rs[i] = s; rt[i] = t; dst[i] = d; stalls_of[i] = 0;
  endtask

  // Reference: wait when the needed value cannot be forwarded in time.
  function automatic bit ref_stall(input int di, input int ei, input int mi);
    int a, b, ek, ed, mk, md;
    bit wait_req;
    if (di < 0) return 0;
    a = rs[di]; b = rt[di];
    ek = (ei < 0) ? NOP : kind[ei]; ed = (ei < 0) ? 0 : dst[ei];
    mk = (mi < 0) ? NOP : kind[mi]; md = (mi < 0) ? 0 : dst[mi];
    wait_req = 0;
    if (ek == LD && ed != 0 && (ed == a || ed == b)) wait_req = 1;
    if (kind[di] == BR) begin
      if (ek == ALU && ed != 0 && (ed == a || ed == b)) wait_req = 1;
      if (mk == LD && md != 0 && (md == a || md == b)) wait_req = 1;
    end
    return wait_req;
  endfunction

  initial begin
    int pc, fd, ex, mm, total;
    bit exp;
    @(negedge clk);
    // Idle state
    drive(0, 0, 0, 0, 0, 0, 0, 0); check_out(0, "R7 idle");
    drive(3, 4, 0, 1, 3, 0, 0, 0); check_out(1, "R1 load dst matches src a");
    drive(7, 9, 0, 1, 9, 0, 0, 0); check_out(1, "R1 load dst matches src b");
    drive(7, 9, 1, 1, 9, 0, 0, 0); check_out(1, "R1 load ahead of branch");
    drive(7, 9, 0, 1, 8, 0, 0, 0); check_out(0, "R7 load dst differs");
    drive(0, 0, 0, 1, 0, 0, 0, 0); check_out(0, "R6 load into register zero");
    drive(5, 6, 1, 0, 0, 6, 0, 0); check_out(1, "R3 branch behind ALU");
    drive(5, 6, 0, 0, 0, 6, 0, 0); check_out(0, "R7 non-branch behind ALU");
    drive(0, 6, 1, 0, 0, 0, 0, 0); check_out(0, "R6 branch behind non-writer");
    drive(5, 6, 1, 0, 0, 0, 1, 5); check_out(1, "R4 branch, load two ahead");
    drive(5, 6, 0, 0, 0, 0, 1, 5); check_out(0, "R7 non-branch, load two ahead");
    drive(0, 6, 1, 0, 0, 0, 1, 0); check_out(0, "R6 branch, load two ahead into zero");
    drive(5, 6, 1, 1, 3, 6, 0, 0); check_out(0, "R3 ALU field ignored when execute holds a load");

    // Pipeline run
    set_instr(0,  LD, 3, 2, 2);
    set_instr(1,  ALU, 2, 5, 12);
    set_instr(2,  ALU, 6, 2, 13);
    set_instr(3,  ALU, 5, 6, 4);
    set_instr(4,  BR, 4, 1, 0);
    set_instr(5,  LD, 7, 1, 1);
    set_instr(6,  ALU, 8, 9, 7);
    set_instr(7,  BR, 1, 0, 0);
    set_instr(8,  LD, 2, 3, 3);
    set_instr(9,  BR, 3, 0, 0);
    set_instr(10, ALU, 1, 2, 0);
    set_instr(11, BR, 0, 0, 0);
    set_instr(12, LD, 4, 0, 0);
    set_instr(13, ALU, 0, 0, 14);
    pc = 0; fd = -1; ex = -1; mm = -1; total = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      drive(fd < 0 ? 0 : rs[fd], fd < 0 ? 0 : rt[fd], fd >= 0 && kind[fd] == BR,
            ex >= 0 && kind[ex] == LD, ex < 0 ? 0 : dst[ex],
            (ex >= 0 && kind[ex] == ALU) ? dst[ex] : 0,
            mm >= 0 && kind[mm] == LD, mm < 0 ? 0 : dst[mm]);
      exp = ref_stall(fd, ex, mm);
      check_out(exp, "R2 pipeline cycle");
      if (exp) begin stalls_of[fd]++; total++; end
      @(posedge clk);
      mm = ex;
      if (exp) ex = -1;
      else begin
        ex = fd;
        fd = (pc < NPROG) ? pc : -1;
        if (pc < NPROG) pc++;
      end
    end
    checks++; if (stalls_of[9] != 2) begin fails++; $display("FAIL R5: branch after load held %0d expected 2", stalls_of[9]); end
    checks++; if (stalls_of[1] != 1) begin fails++; $display("FAIL R8: load-use held %0d expected 1", stalls_of[1]); end
    checks++; if (stalls_of[4] != 1) begin fails++; $display("FAIL R8: branch after ALU held %0d expected 1", stalls_of[4]); end
    checks++; if (stalls_of[7] != 1) begin fails++; $display("FAIL R4: branch two after load held %0d expected 1", stalls_of[7]); end
    checks++; if (stalls_of[11] + stalls_of[13] != 0) begin fails++; $display("FAIL R6: zero-register stalls %0d expected 0", stalls_of[11] + stalls_of[13]); end
    checks++; if (total != 5) begin fails++; $display("FAIL R7: total stalls %0d expected 5", total); end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule